// File: doc/BRIEF.md
# Flash write suspend-resume controller

This block sits behind the command decoder of a serial flash and keeps the status of the internal write engine while a long erase or program is paused and restarted. The decoder has already framed each command (chip select low, one opcode cycle, chip select high) and turns it into a one-cycle strobe. Opcode 0x06 sets the write-enable latch and opcode 0x30 resumes a paused write. Other strobes start an operation of a given kind, pause it, and enter or leave the performance-enhance read mode. A modelled timer reports the end of the running operation with a one-cycle done pulse.

The block drives the busy bit, the write-enable latch, one status bit for a paused erase and one for a paused program, and three flags that name the paused operation as sector erase, block erase or page program. After each resume a hold-off counter of `HOLD_CYC` clock cycles runs. The default is 1 ms at 50 MHz. No suspend can take effect while the counter runs. While the performance-enhance mode is active, a resume is refused.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset, and on any later reset, every output is 0.
- R2: `cmd_wren` sets `wel` on the next edge. `cmd_start` is accepted only when `wel` is 1, the engine is neither busy nor paused, and `start_kind` is not 3. The kind codes are 0 for sector erase, 1 for block erase and 2 for page program. An accepted start sets `busy` and clears `wel`. A refused start changes nothing. If `cmd_wren` arrives in the same cycle as the start, `wel` ends up 1.
- R3: `op_done` while busy clears `busy`. `op_done` while paused or idle is ignored. When `op_done` and `cmd_suspend` arrive in the same cycle, the done wins and nothing is paused.
- R4: `cmd_suspend` while busy, with the hold-off expired, clears `busy`. It sets `erase_susp` for kinds 0 and 1, or `prog_susp` for kind 2, and raises exactly one of `susp_sector`, `susp_block` and `susp_page`. A suspend while idle is ignored.
- R5: An accepted resume clears both pause bits and all three kind flags and sets `busy`. A later `op_done` then clears `busy`.
- R6: A resume neither needs nor changes `wel`.
- R7: A resume when nothing is paused changes no output, and it does not start the hold-off.
- R8: `cmd_perf_enter` sets `perf_mode` and `cmd_perf_exit` clears it. If both arrive in the same cycle, the exit wins. A resume while `perf_mode` is 1 is ignored, and the first resume after the exit takes effect.
- R9: An accepted resume on edge k sets `holdoff_active` and loads the hold-off counter. A suspend sampled on edge k+N is dropped for N <= `HOLD_CYC` and accepted for N > `HOLD_CYC`. `holdoff_active` falls on edge k+`HOLD_CYC`. A dropped suspend is not kept for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_start | input | 1 | Start an erase or program |
| start_kind | input | 2 | Kind of the start: 0 sector erase, 1 block erase, 2 page program, 3 refused |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_perf_enter | input | 1 | Enter performance-enhance mode |
| cmd_perf_exit | input | 1 | Leave performance-enhance mode |
| op_done | input | 1 | Completion pulse from the modelled write timer |
| busy | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |
| erase_susp | output | 1 | An erase is paused |
| prog_susp | output | 1 | A program is paused |
| susp_sector | output | 1 | The paused operation is a sector erase |
| susp_block | output | 1 | The paused operation is a block erase |
| susp_page | output | 1 | The paused operation is a page program |
| perf_mode | output | 1 | Performance-enhance mode is active |
| holdoff_active | output | 1 | The hold-off after a resume is still running |

## Verification
The bench probes the hold-off window on both sides of its edge. A counter that is off by one would accept the suspend on edge k+`HOLD_CYC`, or refuse it on edge k+`HOLD_CYC`+1. A design that queued the dropped suspend would pause the engine without any new command. The bench also sends a resume while performance-enhance mode is active. A design that ignored the mode would clear the pause bits there, and one that latched the refusal would stay stuck after the exit. Further cases are a resume with no pause pending, a resume with `wel` set, a done that arrives while paused, and a done that arrives together with a suspend. A design that consumed `wel`, restarted a paused engine, or let the suspend win would each show a wrong `busy`, `wel` or pause bit on the next edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    OP_SECTOR = 2'd0,
    OP_BLOCK  = 2'd1,
    OP_PAGE   = 2'd2,
    OP_NONE   = 2'd3
  } op_kind_e;

  // true for the two erase kinds
  function automatic logic is_erase(op_kind_e k);
    return (k == OP_SECTOR) || (k == OP_BLOCK);
  endfunction

  // {page, block, sector} flags for a kind
  function automatic logic [2:0] kind_flags(op_kind_e k);
    logic [2:0] f;
    f = 3'b000;
    case (k)
      OP_SECTOR: f = 3'b001;
      OP_BLOCK:  f = 3'b010;
      OP_PAGE:   f = 3'b100;
      default:   f = 3'b000;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fsr_holdoff.sv
module fsr_holdoff #(
  parameter int HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic active
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (arm)          cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  assert_arm_starts_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> active);

endmodule

// File: rtl/fsr_wel.sv
module fsr_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic wel
);
  always_ff @(posedge clk) begin
    if (!rst_n)   wel <= 1'b0;
    else if (set) wel <= 1'b1;
    else if (clr) wel <= 1'b0;
  end

  assert_consume_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !wel);
endmodule

// File: rtl/fsr_engine.sv
module fsr_engine
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] kind,
  input  logic       wel,
  input  logic       suspend,
  input  logic       resume,
  input  logic       perf_on,
  input  logic       perf_off,
  input  logic       done,
  input  logic       hold_busy,
  output logic       busy,
  output logic       erase_susp,
  output logic       prog_susp,
  output logic [2:0] susp_flags,
  output logic       perf,
  output logic       start_acc,
  output logic       susp_acc,
  output logic       res_acc
);
  op_kind_e kind_q;
  logic     busy_q, paused_q, perf_q;
  logic     done_acc;

  assign start_acc = start && wel && !busy_q && !paused_q && (op_kind_e'(kind) != OP_NONE);
  assign done_acc  = done && busy_q;
  assign susp_acc  = suspend && busy_q && !done && !hold_busy;
  assign res_acc   = resume && paused_q && !perf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      paused_q <= 1'b0;
      kind_q   <= OP_SECTOR;
    end else begin
      if (start_acc) begin
        busy_q <= 1'b1;
        kind_q <= op_kind_e'(kind);
      end
      if (done_acc) busy_q <= 1'b0;
      if (susp_acc) begin
        busy_q   <= 1'b0;
        paused_q <= 1'b1;
      end
      if (res_acc) begin
        busy_q   <= 1'b1;
        paused_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        perf_q <= 1'b0;
    else if (perf_off) perf_q <= 1'b0;
    else if (perf_on)  perf_q <= 1'b1;
  end

  assign busy       = busy_q;
  assign perf       = perf_q;
  assign erase_susp = paused_q && is_erase(kind_q);
  assign prog_susp  = paused_q && (kind_q == OP_PAGE);
  assign susp_flags = paused_q ? kind_flags(kind_q) : 3'b000;

  assert_one_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(susp_flags) && !(erase_susp && prog_susp));
  assert_suspend_pauses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    susp_acc |=> !busy && (erase_susp || prog_susp));
  assert_resume_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_acc |=> busy && !erase_susp && !prog_susp && (susp_flags == 3'b000));
  assert_perf_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && perf_q && !suspend) |=> $stable(paused_q));
  assert_window_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && busy_q && !done && hold_busy && !start) |=> busy);
  assert_idle_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !paused_q && !done && !start && !suspend) |=> $stable(busy) && $stable(paused_q));
  assert_done_paused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && paused_q && !resume) |=> !busy);

endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl #(
  parameter int HOLD_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wren,
  input  logic       cmd_start,
  input  logic [1:0] start_kind,
  input  logic       cmd_suspend,
  input  logic       cmd_resume,
  input  logic       cmd_perf_enter,
  input  logic       cmd_perf_exit,
  input  logic       op_done,
  output logic       busy,
  output logic       wel,
  output logic       erase_susp,
  output logic       prog_susp,
  output logic       susp_sector,
  output logic       susp_block,
  output logic       susp_page,
  output logic       perf_mode,
  output logic       holdoff_active
);
  logic       start_acc, susp_acc, res_acc;
  logic [2:0] flags;

  fsr_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cmd_wren),
    .clr   (start_acc),
    .wel   (wel)
  );

  fsr_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (res_acc),
    .active (holdoff_active)
  );

  fsr_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cmd_start),
    .kind       (start_kind),
    .wel        (wel),
    .suspend    (cmd_suspend),
    .resume     (cmd_resume),
    .perf_on    (cmd_perf_enter),
    .perf_off   (cmd_perf_exit),
    .done       (op_done),
    .hold_busy  (holdoff_active),
    .busy       (busy),
    .erase_susp (erase_susp),
    .prog_susp  (prog_susp),
    .susp_flags (flags),
    .perf       (perf_mode),
    .start_acc  (start_acc),
    .susp_acc   (susp_acc),
    .res_acc    (res_acc)
  );

  assign susp_sector = flags[0];
  assign susp_block  = flags[1];
  assign susp_page   = flags[2];

  assert_resume_keeps_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_resume && !cmd_wren && !cmd_start) |=> $stable(wel));
  assert_no_suspend_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff_active |-> !susp_acc);

endmodule

// File: tb/flash_susp_ctrl_tb.sv
module flash_susp_ctrl_tb;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_start = 0, cmd_suspend = 0, cmd_resume = 0;
  logic cmd_perf_enter = 0, cmd_perf_exit = 0, op_done = 0;
  logic [1:0] start_kind = 2'd0;
  logic busy, wel, erase_susp, prog_susp, susp_sector, susp_block, susp_page;
  logic perf_mode, holdoff_active;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  always #10 clk = ~clk;

  flash_susp_ctrl #(.HOLD_CYC(H)) u_dut (.*);

  // stim {wren,start,kind[1:0],susp,resume,pen,pex,done}
  // exp  {busy,wel,esus,psus,sec,blk,pg,perf,hold}
  typedef struct packed {
    logic [8:0] stim;
    logic [8:0] exp;
    logic [3:0] req;
  } row_t;

  localparam int NROW = 31;
  localparam row_t TBL [NROW] = '{
    '{9'b1_0_00_0_0_0_0_0, 9'b0_1_0_0_000_0_0, 4'd2}, // R2 wren
    '{9'b0_1_00_0_0_0_0_0, 9'b1_0_0_0_000_0_0, 4'd2}, // R2 start sector
    '{9'b0_0_00_1_0_0_0_0, 9'b0_0_1_0_100_0_0, 4'd4}, // R4 pause erase
    '{9'b0_0_00_0_0_0_0_1, 9'b0_0_1_0_100_0_0, 4'd3}, // R3 done while paused
    '{9'b0_0_00_0_1_0_0_0, 9'b1_0_0_0_000_0_1, 4'd5}, // R5 resume
    '{9'b0_0_00_1_0_0_0_0, 9'b1_0_0_0_000_0_1, 4'd9}, // R9 N=1 dropped
    '{9'b0_0_00_0_0_0_0_0, 9'b1_0_0_0_000_0_1, 4'd9}, // R9
    '{9'b0_0_00_0_0_0_0_0, 9'b1_0_0_0_000_0_1, 4'd9}, // R9
    '{9'b0_0_00_0_0_0_0_0, 9'b1_0_0_0_000_0_0, 4'd9}, // R9 window closes, no queued pause
    '{9'b0_0_00_1_0_0_0_0, 9'b0_0_1_0_100_0_0, 4'd9}, // R9 N=5 accepted
    '{9'b0_0_00_0_0_1_0_0, 9'b0_0_1_0_100_1_0, 4'd8}, // R8 enter
    '{9'b0_0_00_0_1_0_0_0, 9'b0_0_1_0_100_1_0, 4'd8}, // R8 resume refused
    '{9'b0_0_00_0_0_0_1_0, 9'b0_0_1_0_100_0_0, 4'd8}, // R8 exit
    '{9'b0_0_00_0_1_0_0_0, 9'b1_0_0_0_000_0_1, 4'd8}, // R8 resume now works
    '{9'b0_0_00_0_0_0_0_1, 9'b0_0_0_0_000_0_1, 4'd5}, // R5 done after resume
    '{9'b0_0_00_0_1_0_0_0, 9'b0_0_0_0_000_0_1, 4'd7}, // R7 idle resume
    '{9'b1_0_00_0_0_0_0_0, 9'b0_1_0_0_000_0_1, 4'd2}, // R2
    '{9'b0_1_10_0_0_0_0_0, 9'b1_0_0_0_000_0_0, 4'd2}, // R2 start page
    '{9'b1_0_00_0_0_0_0_0, 9'b1_1_0_0_000_0_0, 4'd2}, // R2 wren while busy
    '{9'b0_0_00_1_0_0_0_0, 9'b0_1_0_1_001_0_0, 4'd4}, // R4 pause program
    '{9'b0_0_00_0_1_0_0_0, 9'b1_1_0_0_000_0_1, 4'd6}, // R6 wel untouched
    '{9'b0_0_00_0_0_0_0_1, 9'b0_1_0_0_000_0_1, 4'd6}, // R6
    '{9'b0_1_01_0_0_0_0_0, 9'b1_0_0_0_000_0_1, 4'd2}, // R2 start block
    '{9'b0_0_00_0_0_0_0_0, 9'b1_0_0_0_000_0_1, 4'd9}, // R9
    '{9'b0_0_00_0_0_0_0_0, 9'b1_0_0_0_000_0_0, 4'd9}, // R9
    '{9'b0_0_00_1_0_0_0_0, 9'b0_0_1_0_010_0_0, 4'd4}, // R4 pause block
    '{9'b0_0_00_0_1_0_0_0, 9'b1_0_0_0_000_0_1, 4'd5}, // R5
    '{9'b0_0_00_0_0_0_0_1, 9'b0_0_0_0_000_0_1, 4'd3}, // R3
    '{9'b0_1_00_0_0_0_0_0, 9'b0_0_0_0_000_0_1, 4'd2}, // R2 start without wel
    '{9'b1_0_00_0_0_0_0_0, 9'b0_1_0_0_000_0_1, 4'd2}, // R2
    '{9'b0_1_11_0_0_0_0_0, 9'b0_1_0_0_000_0_0, 4'd2}  // R2 kind 3 refused
  };

  function automatic logic [8:0] outs();
    return {busy, wel, erase_susp, prog_susp, susp_sector, susp_block, susp_page,
            perf_mode, holdoff_active};
  endfunction

  task automatic drive(input logic [8:0] s);
    @(negedge clk);
    {cmd_wren, cmd_start, start_kind, cmd_suspend, cmd_resume,
     cmd_perf_enter, cmd_perf_exit, op_done} = s;
  endtask

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  // apply one strobe set, sample after the edge that registers it
  task automatic step(input logic [8:0] s, input string tag, input logic [8:0] exp);
    drive(s);
    @(posedge clk);
    #5;
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset state", 9'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++)
      step(TBL[i].stim, $sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp);

    // R4: suspend while idle (holdoff already expired)
    step(9'b0_0_00_1_0_0_0_0, "R4 idle suspend", 9'b0_1_0_0_000_0_0);
    // R3: done and suspend together, done wins
    step(9'b0_1_00_0_0_0_0_0, "R2 start", 9'b1_0_0_0_000_0_0);
    step(9'b0_0_00_1_0_0_0_1, "R3 done beats suspend", 9'b0_0_0_0_000_0_0);
    // R8: enter and exit together, exit wins
    step(9'b0_0_00_0_0_1_1_0, "R8 exit wins", 9'b0_0_0_0_000_0_0);
    // R1: reset while paused
    step(9'b1_0_00_0_0_0_0_0, "R2 wren", 9'b0_1_0_0_000_0_0);
    step(9'b0_1_10_0_0_0_0_0, "R2 start", 9'b1_0_0_0_000_0_0);
    step(9'b0_0_00_1_0_1_0_0, "R4 pause", 9'b0_0_0_1_001_1_0);
    drive(9'b0);
    rst_n = 1'b0;
    @(posedge clk);
    #5;
    check("R1 reset mid pause", 9'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(9'b0_0_00_0_1_0_0_0, "R7 resume after reset", 9'b0);
    drive(9'b0);
    done_run = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done_run; c++) @(posedge clk);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule